// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a three-wire serial audio link (bit clock, frame clock that selects left or right, serial data) and turns it into parallel channel words in the system clock domain. All three link wires are brought through two-stage synchronizers. The rising edges of the bit clock are found by oversampling it with the system clock. Every received word is left-aligned into a 24-bit output. It comes out with a channel flag and a strobe that lasts one system clock.

Three framings are decoded:
- **I2S-style.** The first data bit trails the frame-clock change by one bit period, and a low frame clock marks the left channel.
- **Left-justified.** The first data bit coincides with the frame-clock change, and a high frame clock marks the left channel.
- **Right-justified.** A high frame clock marks the left channel. Each word ends on the last bit before the next frame-clock change, so the start of the word moves with the word width.

The width and framing inputs are only taken at frame-clock changes. Changing them in the middle of a word cannot produce a word that is partly old format and partly new.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held and after it is released, `word_o` is zero, `right_o` is 0 and `valid_o` is 0 until the first word is complete.
- R2: With `fmt_i` = 0 (I2S-style), a low frame clock means left (`right_o` = 0) and a high one means right. The MSB is the bit sampled one bit period after the frame-clock change, and the following bits follow it MSB first.
- R3: With `fmt_i` = 1 (left-justified), a high frame clock means left and a low one means right. The MSB is the bit sampled on the first bit-clock rise after the frame-clock change.
- R4: With `fmt_i` = 2 or 3 (right-justified), the polarity is the same as in R3. The MSB is the bit at position HALF minus the width, counted from 0 at the first bit after the frame-clock change. With HALF = 32 this gives offsets 16, 14, 12 or 8, so the LSB falls on the last bit before the next change.
- R5: `wsel_i` sets the word width: 0 is 16 bits, 1 is 18, 2 is 20 and 3 is 24. The received bits fill `word_o` from bit 23 downwards, and the unused low bits are zero.
- R6: `valid_o` is high for exactly one system clock per completed word. It rises only after a sampling bit-clock edge. `word_o` and `right_o` change only together with `valid_o` and hold their value in between.
- R7: A change of `fmt_i` or `wsel_i` in the middle of a channel slot does not affect the word being received. It takes effect from the next frame-clock change.
- R8: Serial data clocked in after reset and before the first frame-clock change is ignored. No word is produced, however many bits arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous to `clk` |
| lrck_i | input | 1 | Frame clock selecting left/right slot |
| sdat_i | input | 1 | Serial data, sampled at bit-clock rise |
| fmt_i | input | 2 | Framing: 0 I2S-style, 1 left-justified, 2/3 right-justified |
| wsel_i | input | 2 | Word width: 0=16, 1=18, 2=20, 3=24 bits |
| word_o | output | 24 | Received word, left-aligned, zero-filled |
| right_o | output | 1 | Channel of `word_o`: 0 left, 1 right |
| valid_o | output | 1 | One-cycle strobe for a new word |

## Verification
The bench uses the default parameters. SW is 24 and HALF is 32, which gives a 64-bit-clock frame. With those values every right-justified offset (16, 14, 12, 8) and every width can be reached, both inside one frame and across frames. The bit clock runs at one eighth of the system clock, which leaves room for the synchronizer latency. Each framing is driven with its own frame-clock polarity. A config change in the middle of a slot is used to show that the new settings only apply at the following frame-clock change.

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
module serial_audio_rx #(
  parameter int SW   = 24,
  parameter int HALF = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk_i,
  input  logic          lrck_i,
  input  logic          sdat_i,
  input  logic [1:0]    fmt_i,
  input  logic [1:0]    wsel_i,
  output logic [SW-1:0] word_o,
  output logic          right_o,
  output logic          valid_o
);
  localparam int CW = $clog2(2 * HALF);
  localparam logic [7:0] HALF8 = 8'(HALF);
  localparam logic [7:0] SW8 = 8'(SW);

  function automatic logic [7:0] wbits(input logic [1:0] s);
    case (s)
      2'd0:    wbits = 8'd16;
      2'd1:    wbits = 8'd18;
      2'd2:    wbits = 8'd20;
      default: wbits = 8'd24;
    endcase
  endfunction

  logic [2:0] bclk_q;
  logic [1:0] lr_q, sd_q;
  logic       seen, lr_prev, armed, chan;
  logic [1:0] fmt_a, w_a;
  logic [CW-1:0] pos;
  logic [SW-1:0] shreg;

  wire rise    = bclk_q[1] & ~bclk_q[2];
  wire lr      = lr_q[1];
  wire sd      = sd_q[1];
  wire lr_edge = seen & (lr != lr_prev);

  wire [1:0] fmt_n   = lr_edge ? fmt_i : fmt_a;
  wire [1:0] w_n     = lr_edge ? wsel_i : w_a;
  wire       armed_n = armed | lr_edge;
  wire       chan_n  = lr_edge ? ((fmt_i == 2'd0) ? lr : ~lr) : chan;
  wire [CW-1:0] cur  = lr_edge ? '0 : pos;

  wire [7:0] wn   = wbits(w_n);
  wire [7:0] off  = (fmt_n == 2'd0) ? 8'd1 : (fmt_n == 2'd1) ? 8'd0 : HALF8 - wn;
  wire [7:0] cur8 = 8'(cur);
  wire inwin = armed_n && (cur8 >= off) && (cur8 < off + wn);
  wire last  = inwin && (cur8 == off + wn - 8'd1);
  wire [SW-1:0] shnext = {shreg[SW-2:0], sd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= '0;
      lr_q   <= '0;
      sd_q   <= '0;
    end else begin
      bclk_q <= {bclk_q[1:0], bclk_i};
      lr_q   <= {lr_q[0], lrck_i};
      sd_q   <= {sd_q[0], sdat_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      lr_prev <= 1'b0;
      armed   <= 1'b0;
      chan    <= 1'b0;
      fmt_a   <= '0;
      w_a     <= '0;
      pos     <= '0;
      shreg   <= '0;
      word_o  <= '0;
      right_o <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise) begin
        seen    <= 1'b1;
        lr_prev <= lr;
        armed   <= armed_n;
        chan    <= chan_n;
        fmt_a   <= fmt_n;
        w_a     <= w_n;
        pos     <= (&cur) ? cur : cur + 1'b1;
        if (inwin) shreg <= shnext;
        if (last) begin
          word_o  <= shnext << (SW8 - wn);
          right_o <= chan_n;
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx_chk.sv
`timescale 1ns/1ps
module serial_audio_rx_chk #(
  parameter int SW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [SW-1:0] word_o,
  input logic          right_o,
  input logic          valid_o,
  input logic          rise,
  input logic          lr_edge,
  input logic          armed,
  input logic [1:0]    fmt_a,
  input logic [1:0]    w_a
);
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r6_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(rise));
  a_r6_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({word_o, right_o}) |-> valid_o);
  a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && w_a == 2'd0) |-> (word_o[7:0] == 8'd0));
  a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && lr_edge) |=> ($stable(fmt_a) && $stable(w_a)));
  a_r8_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !valid_o);
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_o(word_o), .right_o(right_o),
  .valid_o(valid_o), .rise(rise), .lr_edge(lr_edge), .armed(armed),
  .fmt_a(fmt_a), .w_a(w_a)
);

// File: tb/serial_audio_rx_tb.sv
`timescale 1ns/1ps
module serial_audio_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 32;
  localparam int BQ = 4;

  logic clk = 0, rst_n = 0;
  logic bclk = 0, lrck = 0, sdat = 0;
  logic [1:0] fmt_r = 0, wsel_r = 0;
  logic [23:0] word_o;
  logic right_o, valid_o;

  int tests = 0, fails = 0;
  int ncap = 0, rd = 0;
  logic [23:0] cap_d [0:127];
  logic        cap_r [0:127];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_audio_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrck_i(lrck), .sdat_i(sdat),
    .fmt_i(fmt_r), .wsel_i(wsel_r), .word_o(word_o), .right_o(right_o),
    .valid_o(valid_o)
  );

  always @(negedge clk) begin
    if (valid_o && ncap < 128) begin
      cap_d[ncap] = word_o;
      cap_r[ncap] = right_o;
      ncap = ncap + 1;
    end
  end

  function automatic int wb(input logic [1:0] s);
    return (s == 0) ? 16 : (s == 1) ? 18 : (s == 2) ? 20 : 24;
  endfunction

  function automatic logic [23:0] expw(input logic [1:0] s, input logic [23:0] w);
    logic [23:0] m;
    m = (24'h1 << wb(s)) - 24'h1;
    return (w & m) << (24 - wb(s));
  endfunction

  task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_clk(input logic lv, input logic d);
    bclk = 0; lrck = lv; sdat = d;
    repeat (BQ) @(posedge clk);
    bclk = 1;
    repeat (BQ) @(posedge clk);
  endtask

  task automatic gap(input logic lv, input int n);
    for (int i = 0; i < n; i++) bit_clk(lv, 1'b1);
  endtask

  task automatic send_half(input logic [1:0] f, input logic [1:0] s, input logic [23:0] w,
                           input logic lv, input bit chg, input logic [1:0] nf, input logic [1:0] ns);
    int W, off;
    W = wb(s);
    off = (f == 0) ? 1 : (f == 1) ? 0 : HALF - W;
    for (int i = 0; i < HALF; i++) begin
      if (chg && i == 10) begin fmt_r = nf; wsel_r = ns; end
      if (i >= off && i < off + W) bit_clk(lv, w[W-1-(i-off)]);
      else bit_clk(lv, 1'b0);
    end
  endtask

  task automatic expect_word(input string req, input logic r, input logic [23:0] d);
    if (rd >= ncap) check(req, 1'b0, 32'hdead, {8'h0, d});
    else begin
      check(req, cap_d[rd] == d && cap_r[rd] == r, {7'h0, cap_r[rd], cap_d[rd]}, {7'h0, r, d});
      rd++;
    end
  endtask

  task automatic settle_and_count(input string req);
    repeat (8) @(posedge clk);
    check(req, ncap == rd, ncap, rd);
  endtask

  // fmt: 0 I2S-style, 1 left-justified, 2/3 right-justified
  task automatic frame(input string req, input logic [1:0] f, input logic [1:0] s,
                       input logic [23:0] l, input logic [23:0] r);
    logic ll;
    ll = (f == 0) ? 1'b0 : 1'b1;
    fmt_r = f; wsel_r = s;
    if (lrck == ll) gap(~ll, 4);
    send_half(f, s, l, ll, 0, 0, 0);
    send_half(f, s, r, ~ll, 0, 0, 0);
    repeat (8) @(posedge clk);
    expect_word(req, 1'b0, expw(s, l));
    expect_word(req, 1'b1, expw(s, r));
    settle_and_count(req);
  endtask

  task automatic t_reset;
    #1;
    check("R1 word", word_o == 0, word_o, 0);
    check("R1 valid", valid_o == 0, valid_o, 0);
    repeat (3) @(posedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 post", word_o == 0 && !right_o && !valid_o, {word_o, right_o, valid_o}, 0);
  endtask

  task automatic t_unarmed; // R8
    fmt_r = 1; wsel_r = 0;
    gap(1'b0, 40);
    repeat (8) @(posedge clk);
    check("R8 no word before edge", ncap == 0, ncap, 0);
  endtask

  task automatic t_midchange; // R7
    fmt_r = 1; wsel_r = 3;
    if (lrck == 1'b1) gap(1'b0, 4);
    send_half(1, 3, 24'hC0FFEE, 1'b1, 1, 2, 0);
    send_half(2, 0, 24'h00BEEF, 1'b0, 0, 0, 0);
    repeat (8) @(posedge clk);
    expect_word("R7 left keeps 24b LJ", 1'b0, 24'hC0FFEE);
    expect_word("R7 right uses 16b RJ", 1'b1, 24'hBEEF00);
    settle_and_count("R7 count");
  endtask

  initial begin
    t_reset();
    t_unarmed();
    frame("R3 LJ 24", 1, 3, 24'hA5C3F1, 24'h3C5A96);
    frame("R3 R5 LJ 16", 1, 0, 24'h00F00D, 24'h008001);
    frame("R2 I2S 18", 0, 1, 24'h02ABCD, 24'h01357B);
    frame("R2 I2S 24", 0, 3, 24'h800001, 24'h7FFFFE);
    frame("R4 RJ 20", 2, 2, 24'h0FEDCB, 24'h012345);
    frame("R4 RJ 24", 2, 3, 24'h89ABCD, 24'hFEDCBA);
    frame("R4 RJ 16", 2, 0, 24'h00FFFF, 24'h00A001);
    frame("R4 R5 RJ 18 fmt3", 3, 1, 24'h03C3C3, 24'h020001);
    frame("R5 I2S 20", 0, 2, 24'h0ABCDE, 24'h080001);
    t_midchange();
    check("R6 total words", ncap == 20, ncap, 20);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule